// File: doc/BRIEF.md
# Power Mode Controller

This block sequences a chip between four power modes. Normal and Slow keep the CPU running. Idle and Sleep save power. Software picks the next mode by writing a two-bit mode code together with a one-cycle strobe.

From the current state the block decodes a set of enables:
- a CPU clock enable;
- a PLL enable;
- a select that switches the system onto a low-frequency clock with the PLL bypassed;
- one clock enable per peripheral;
- a core power enable.

Idle stops only the CPU clock. Any enabled interrupt then returns the block to the mode that was active before Idle. Sleep removes core power and turns off every clock. A wake source brings the block out of Sleep. The wake sources are sixteen external interrupt lines and a real-time-clock alarm, each passed through a synchronizer.

When the block leaves Sleep, core power and the PLL come back first. A down-counter, loaded from a software value, then waits for them to settle. Only after that wait does the block return to Normal with the clocks enabled. A software mask of per-peripheral enables is ANDed with the mode gating.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block is in Normal. In Normal, `mode_o`=0, `cpu_clk_en`=1, `pll_en`=1, `slow_clk_sel`=0, `core_pwr_en`=1 and `periph_clk_en` equals `periph_en_sw`.
- R2: Mode codes are 0 Normal, 1 Slow, 2 Idle and 3 Sleep. In Normal or Slow, a `req_valid` pulse sampled at a clock edge moves the block to the mode in `req_mode`. The outputs show the new mode directly after that edge.
- R3: In Slow, `mode_o`=1, `pll_en`=0, `slow_clk_sel`=1, `cpu_clk_en`=1 and `core_pwr_en`=1.
- R4: In Idle, `mode_o`=2 and `cpu_clk_en`=0, while the peripheral clocks stay on. `pll_en` and `slow_clk_sel` keep the values of the mode that Idle was entered from. Requests are ignored in Idle.
- R5: In Idle, `irq_any` sampled high returns the block to the mode that Idle was entered from.
- R6: In Sleep, `mode_o`=3 and `core_pwr_en`=0, and `cpu_clk_en`, `pll_en`, `slow_clk_sel` and every `periph_clk_en` bit are 0. Requests and `irq_any` are ignored in Sleep.
- R7: Any bit of `eint` or `rtc_alarm` counts as a wake source. A wake source that is high at edge k is seen by the controller at edge k+2, after two synchronizer stages. In Sleep, the controller then enters a settle phase.
- R8: During the settle phase, `core_pwr_en`=1, `pll_en`=1 and `mode_o`=3, and the CPU and peripheral clocks stay off. The phase lasts `settle_cycles`+1 cycles and is followed by Normal.
- R9: `settle_cycles` is captured when the wake is seen. Changing it during the settle phase does not change the length of that phase.
- R10: `periph_clk_en` is always `periph_en_sw` ANDed with the mode gating. The gating is all ones in Normal, Slow and Idle, and zero otherwise.
- R11: A Sleep request is ignored, and the block stays in its current mode, when a synchronized wake source is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode code |
| irq_any | input | 1 | Any enabled interrupt; ends Idle |
| eint | input | NEINT (16) | External wake lines, asynchronous |
| rtc_alarm | input | 1 | Real-time-clock alarm wake, asynchronous |
| settle_cycles | input | CNT_W (8) | Settle wait length minus one |
| periph_en_sw | input | NPERIPH (8) | Software per-peripheral clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| pll_en | output | 1 | PLL enable |
| slow_clk_sel | output | 1 | Select the low-frequency clock |
| periph_clk_en | output | NPERIPH (8) | Final peripheral clock enables |
| core_pwr_en | output | 1 | Core power enable |
| mode_o | output | 2 | Current mode code |

## Verification
The hardest case to reach is a Sleep request that lands while a wake source is already inside the synchronizer. The request has to be ignored when the synchronized wake is high. If the wake has not yet reached the last synchronizer stage, the request is accepted and the block then wakes at once.

To reach this case, the stimulus holds external lines high before requesting Sleep. It also raises a line one and two cycles before the request strobe. A long random phase then mixes requests, interrupts and single-cycle wake pulses.

A per-cycle reference model tracks the synchronizer delay and the settle count. Every output is compared against it on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLOW   = 2'd1,
    MODE_IDLE   = 2'd2,
    MODE_SLEEP  = 2'd3
  } pmc_mode_e;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_SLOW   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_SETTLE = 3'd4
  } pmc_state_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH  = 17,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pmc_settle_cnt.sv
module pmc_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load || !done;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  pmc_mode_e  req_mode,
  input  logic       irq_any,
  input  logic       wake_s,
  input  logic       settle_done,
  output pmc_state_e state_o,
  output logic       ret_slow_o,
  output logic       settle_load
);
  pmc_state_e state_q, state_d;
  logic       ret_slow_q, ret_slow_d, ret_en;

  always_comb begin
    state_d     = state_q;
    ret_slow_d  = ret_slow_q;
    ret_en      = 1'b0;
    settle_load = 1'b0;
    unique case (state_q)
      ST_NORMAL, ST_SLOW: begin
        if (req_valid) begin
          unique case (req_mode)
            MODE_NORMAL: state_d = ST_NORMAL;
            MODE_SLOW:   state_d = ST_SLOW;
            MODE_IDLE: begin
              state_d    = ST_IDLE;
              ret_en     = 1'b1;
              ret_slow_d = (state_q == ST_SLOW);
            end
            MODE_SLEEP: begin
              if (!wake_s) state_d = ST_SLEEP;
            end
            default: state_d = state_q;
          endcase
        end
      end
      ST_IDLE: begin
        if (irq_any) state_d = ret_slow_q ? ST_SLOW : ST_NORMAL;
      end
      ST_SLEEP: begin
        if (wake_s) begin
          state_d     = ST_SETTLE;
          settle_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_done) state_d = ST_NORMAL;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_slow_q <= 1'b0;
    else if (ret_en) ret_slow_q <= ret_slow_d;
  end

  assign state_o    = state_q;
  assign ret_slow_o = ret_slow_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NEINT       = 16,
  parameter int NPERIPH     = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic               irq_any,
  input  logic [NEINT-1:0]   eint,
  input  logic               rtc_alarm,
  input  logic [CNT_W-1:0]   settle_cycles,
  input  logic [NPERIPH-1:0] periph_en_sw,
  output logic               cpu_clk_en,
  output logic               pll_en,
  output logic               slow_clk_sel,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               core_pwr_en,
  output logic [1:0]         mode_o
);
  localparam int WAKE_W = NEINT + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [WAKE_W-1:0] wake_raw, wake_sync;
  logic              wake_s;
  logic              settle_load, settle_done;
  logic              ret_slow;
  pmc_state_e        state;
  logic              gate_on;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wake_raw = {rtc_alarm, eint};

  pmc_sync #(.WIDTH(WAKE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (wake_raw),
    .q     (wake_sync)
  );
  assign wake_s = |wake_sync;

  pmc_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (settle_load),
    .load_val (settle_cycles),
    .done     (settle_done)
  );

  pmc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_mode    (pmc_mode_e'(req_mode)),
    .irq_any     (irq_any),
    .wake_s      (wake_s),
    .settle_done (settle_done),
    .state_o     (state),
    .ret_slow_o  (ret_slow),
    .settle_load (settle_load)
  );

  always_comb begin
    cpu_clk_en   = 1'b0;
    pll_en       = 1'b0;
    slow_clk_sel = 1'b0;
    core_pwr_en  = 1'b1;
    gate_on      = 1'b0;
    mode_o       = MODE_SLEEP;
    unique case (state)
      ST_NORMAL: begin
        cpu_clk_en = 1'b1; pll_en = 1'b1; gate_on = 1'b1; mode_o = MODE_NORMAL;
      end
      ST_SLOW: begin
        cpu_clk_en = 1'b1; slow_clk_sel = 1'b1; gate_on = 1'b1; mode_o = MODE_SLOW;
      end
      ST_IDLE: begin
        pll_en = !ret_slow; slow_clk_sel = ret_slow; gate_on = 1'b1; mode_o = MODE_IDLE;
      end
      ST_SLEEP:  core_pwr_en = 1'b0;
      ST_SETTLE: pll_en = 1'b1;
      default:   core_pwr_en = 1'b0;
    endcase
  end

  assign periph_clk_en = periph_en_sw & {NPERIPH{gate_on}};
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NPERIPH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_clk_en,
  input logic               pll_en,
  input logic               slow_clk_sel,
  input logic [NPERIPH-1:0] periph_clk_en,
  input logic [NPERIPH-1:0] periph_en_sw,
  input logic               core_pwr_en,
  input logic [1:0]         mode_o
);
  // R6
  sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> (!cpu_clk_en && !pll_en && !slow_clk_sel &&
                      periph_clk_en == '0 && mode_o == 2'd3));

  // R4
  idle_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'd2 |-> (!cpu_clk_en && core_pwr_en && periph_clk_en == periph_en_sw));

  // R3
  slow_no_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'd1 |-> (!pll_en && slow_clk_sel && cpu_clk_en));

  // R10
  periph_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_clk_en & ~periph_en_sw) == '0);

  // R8
  power_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_en) |-> (!cpu_clk_en && pll_en && periph_clk_en == '0));

  // R8
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && core_pwr_en) |=> (mode_o == 2'd3 || mode_o == 2'd0));

  // R6
  sleep_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && !core_pwr_en) |=> mode_o == 2'd3);
endmodule

bind pwr_mode_ctrl pmc_chk #(.NPERIPH(NPERIPH)) u_pmc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_clk_en    (cpu_clk_en),
  .pll_en        (pll_en),
  .slow_clk_sel  (slow_clk_sel),
  .periph_clk_en (periph_clk_en),
  .periph_en_sw  (periph_en_sw),
  .core_pwr_en   (core_pwr_en),
  .mode_o        (mode_o)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic        irq_any;
  logic [15:0] eint;
  logic        rtc_alarm;
  logic [7:0]  settle_cycles;
  logic [7:0]  periph_en_sw;
  logic        cpu_clk_en, pll_en, slow_clk_sel, core_pwr_en;
  logic [7:0]  periph_clk_en;
  logic [1:0]  mode_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .irq_any(irq_any), .eint(eint), .rtc_alarm(rtc_alarm),
    .settle_cycles(settle_cycles), .periph_en_sw(periph_en_sw),
    .cpu_clk_en(cpu_clk_en), .pll_en(pll_en), .slow_clk_sel(slow_clk_sel),
    .periph_clk_en(periph_clk_en), .core_pwr_en(core_pwr_en), .mode_o(mode_o)
  );

  // reference model: 0 normal, 1 slow, 2 idle, 3 sleep, 4 settle
  int m_st = 0, m_ret = 0, m_cnt = 0;
  bit m_r1 = 0, m_r2 = 0, m_w1 = 0, m_w2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_w1 = 0; m_w2 = 0;
      m_st = 0; m_ret = 0; m_cnt = 0;
    end else begin
      int  nst, nret, ncnt;
      bit  live, seen;
      live = m_r2;
      m_r2 = m_r1; m_r1 = 1;
      if (!live) begin
        m_st = 0; m_ret = 0; m_cnt = 0; m_w1 = 0; m_w2 = 0;
      end else begin
        seen = m_w2;
        nst = m_st; nret = m_ret; ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
        if (m_st <= 1) begin
          if (req_valid) begin
            if (req_mode == 2) begin nst = 2; nret = m_st; end
            else if (req_mode == 3) begin if (!seen) nst = 3; end
            else nst = req_mode;
          end
        end else if (m_st == 2) begin
          if (irq_any) nst = m_ret;
        end else if (m_st == 3) begin
          if (seen) begin nst = 4; ncnt = settle_cycles; end
        end else begin
          if (m_cnt == 0) nst = 0;
        end
        m_st = nst; m_ret = nret; m_cnt = ncnt;
        m_w2 = m_w1; m_w1 = (|eint) | rtc_alarm;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h (t=%0t)", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    begin
      int e_mode;
      bit e_on;
      e_mode = (m_st == 4) ? 3 : m_st;
      e_on = (m_st <= 2);
      cmp("mode_o", mode_o, e_mode);
      cmp("cpu_clk_en", cpu_clk_en, (m_st <= 1));
      cmp("pll_en", pll_en, (m_st == 0) || (m_st == 2 && m_ret == 0) || (m_st == 4));
      cmp("slow_clk_sel", slow_clk_sel, (m_st == 1) || (m_st == 2 && m_ret == 1));
      cmp("core_pwr_en", core_pwr_en, (m_st != 3));
      cmp("periph_clk_en", periph_clk_en, e_on ? periph_en_sw : 8'h00);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(int md);
    @(negedge clk); req_valid = 1; req_mode = md[1:0];
    @(negedge clk); req_valid = 0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_any = 1;
    @(negedge clk); irq_any = 0;
  endtask

  task automatic pulse_eint(int bitn);
    @(negedge clk); eint = 16'h1 << bitn;
    @(negedge clk); eint = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_mode = 0; irq_any = 0; eint = 0;
    rtc_alarm = 0; settle_cycles = 8'd5; periph_en_sw = 8'hA5;
    phase = "R1";
    idle_n(4);
    rst_n = 1;
    idle_n(6);

    phase = "R10";
    @(negedge clk); periph_en_sw = 8'h3C;
    @(negedge clk); periph_en_sw = 8'hFF;
    @(negedge clk); periph_en_sw = 8'h00;
    @(negedge clk); periph_en_sw = 8'h81;

    phase = "R3"; request(1); idle_n(4);
    @(negedge clk); periph_en_sw = 8'h5A;
    phase = "R4"; request(2); idle_n(3);
    request(0); request(3); idle_n(2);
    phase = "R5"; pulse_irq(); idle_n(3);
    phase = "R2"; request(0); idle_n(2);
    phase = "R4"; request(2); idle_n(2);
    phase = "R5"; pulse_irq(); idle_n(2);

    phase = "R6"; settle_cycles = 8'd5; request(3); idle_n(4);
    request(0); pulse_irq(); idle_n(3);
    phase = "R7"; pulse_eint(7); idle_n(3);
    phase = "R8"; idle_n(8);

    phase = "R9"; settle_cycles = 8'd3; request(3); idle_n(3);
    @(negedge clk); rtc_alarm = 1;
    @(negedge clk); rtc_alarm = 0;
    idle_n(2); settle_cycles = 8'd200; idle_n(8);
    settle_cycles = 8'd0; request(3); idle_n(2); pulse_eint(0); idle_n(5);

    phase = "R11";
    @(negedge clk); eint = 16'h8000; idle_n(3);
    request(3); idle_n(2);
    request(1); request(3); idle_n(2);
    @(negedge clk); eint = 0; idle_n(3);
    request(0);
    @(negedge clk); eint = 16'h0010;
    @(negedge clk); req_valid = 1; req_mode = 2'd3;
    @(negedge clk); req_valid = 0; eint = 0;
    idle_n(6);
    @(negedge clk); eint = 16'h0100; req_valid = 1; req_mode = 2'd3;
    @(negedge clk); req_valid = 0; eint = 0;
    idle_n(8);

    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 5) == 0);
      req_mode = 2'($urandom_range(0, 3));
      irq_any = ($urandom_range(0, 7) == 0);
      eint = ($urandom_range(0, 39) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
      rtc_alarm = ($urandom_range(0, 59) == 0);
      settle_cycles = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) periph_en_sw = 8'($urandom);
    end
    @(negedge clk); req_valid = 0; irq_any = 0; eint = 0; rtc_alarm = 0;
    idle_n(20);

    phase = "R1";
    @(negedge clk); rst_n = 0; idle_n(3);
    rst_n = 1; idle_n(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule